// File: doc/BRIEF.md
# Sequential Signed Float Multiplier

This block multiplies two numbers held in a simple base-two scientific format. Each 32-bit operand packs a signed two's-complement exponent in its upper 8 bits (bits 31:24) and a signed two's-complement fraction in its lower 24 bits (bits 23:0). The result is a 56-bit word. It holds the wrapped sum of the exponents in bits 55:48 and the full signed 48-bit product of the fractions in bits 47:0. Nothing is rounded or truncated.

A single start pulse (`clr`) begins every operation, including a repeat of the same operands. On the clock edge where `clr` is high, the block captures the operands. Each fraction is converted to its magnitude, and the accumulator and step counter are cleared. The magnitudes are then multiplied one bit per cycle by shift-and-add. The multiplicand moves left and the multiplier moves right. The multiplicand is added into the accumulator whenever the multiplier's low bit is set. Completion is signalled as soon as the remaining multiplier bits are all zero, so short multipliers finish early. The output fraction is the two's-complement negation of the magnitude product when exactly one input fraction was negative. A separate flag reports whether the exponent sum fitted in 8 signed bits.

Top module: `fpm_mul`

## Requirements
- R1: A clock edge with `clr` high captures `op_a` and `op_b` and clears the accumulator and step counter. Any operation in progress is abandoned, and the next operation's result does not depend on it.
- R2: After completion, `product[47:0]` equals the signed product of `op_a[23:0]` and `op_b[23:0]` as a 48-bit two's-complement value, for positive and negative inputs alike.
- R3: With nonzero fractions, `done` first reads high after k+1 clock edges following the `clr` edge, where k is the index of the highest set bit of |`op_b[23:0]`|.
- R4: Once `done` is high, it stays high and `product` and `exp_ok` hold their values until the next `clr` edge.
- R5: The product fraction is negative (bit 47 set) exactly when the product is nonzero and exactly one input fraction is negative.
- R6: `product[55:48]` equals the low 8 bits of the signed sum of `op_a[31:24]` and `op_b[31:24]`.
- R7: `exp_ok` is 1 when that exponent sum lies in the range -128 to 127 and 0 otherwise.
- R8: If either input fraction is zero, `done` is high one cycle after the `clr` edge and `product[47:0]` is zero.
- R9: Changes on `op_a` and `op_b` after the `clr` edge have no effect on `product`, `done` or `exp_ok`.
- R10: Every operation completes within 24 clock edges after the `clr` edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| clr | input | 1 | Synchronous start pulse: captures operands and clears the engine |
| op_a | input | 32 | Operand A: exponent in 31:24, fraction in 23:0 (both signed) |
| op_b | input | 32 | Operand B (the multiplier): exponent in 31:24, fraction in 23:0 |
| product | output | 56 | Exponent sum in 55:48, signed 48-bit fraction product in 47:0 |
| done | output | 1 | High once the remaining multiplier bits are all zero |
| exp_ok | output | 1 | High when the exponent sum fits in 8 signed bits |

## Verification
The hardest case to reach from the ports is an operation abandoned partway through. Here a new start pulse must discard a partly filled accumulator and a partly shifted multiplier. The stimulus starts a long multiply and interrupts it with a fresh `clr` after a few cycles. It then checks that the new result matches the model exactly. The most negative fraction, -2^23, is also driven on both inputs. This case forces all 24 shift cycles, and its magnitude only just fits the unsigned width. Operands are deliberately scrambled right after each start pulse, which shows that the captured values alone decide the result.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int DEF_EXP_W  = 8;
  localparam int DEF_FRAC_W = 24;

  typedef enum logic [1:0] {
    PH_LOAD = 2'd0,
    PH_RUN  = 2'd1,
    PH_DONE = 2'd2
  } fpm_phase_e;
endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack #(
  parameter int EXP_W  = fpm_pkg::DEF_EXP_W,
  parameter int FRAC_W = fpm_pkg::DEF_FRAC_W,
  localparam int WORD_W = EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] word,
  output logic [EXP_W-1:0]  expo,
  output logic [FRAC_W-1:0] mag,
  output logic              neg
);
  function automatic logic [FRAC_W-1:0] magnitude(input logic [FRAC_W-1:0] f);
    return f[FRAC_W-1] ? (~f + FRAC_W'(1)) : f;
  endfunction

  assign expo = word[WORD_W-1:FRAC_W];
  assign neg  = word[FRAC_W-1];
  assign mag  = magnitude(word[FRAC_W-1:0]);
endmodule

// File: rtl/fpm_expadd.sv
module fpm_expadd #(
  parameter int EXP_W = fpm_pkg::DEF_EXP_W
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [EXP_W-1:0] exp_a,
  input  logic [EXP_W-1:0] exp_b,
  output logic [EXP_W-1:0] exp_sum,
  output logic             exp_fits
);
  function automatic logic [EXP_W:0] wide_sum(input logic [EXP_W-1:0] a,
                                               input logic [EXP_W-1:0] b);
    return {a[EXP_W-1], a} + {b[EXP_W-1], b};
  endfunction

  logic [EXP_W:0] sum_w;
  assign sum_w = wide_sum(exp_a, exp_b);

  always_ff @(posedge clk) begin
    if (clr) begin
      exp_sum  <= sum_w[EXP_W-1:0];
      exp_fits <= (sum_w[EXP_W] == sum_w[EXP_W-1]);
    end
  end

  // R9
  exp_hold_chk: assert property (@(posedge clk) disable iff (clr)
    1'b1 |=> $stable(exp_sum) && $stable(exp_fits));
endmodule

// File: rtl/fpm_shiftadd.sv
module fpm_shiftadd #(
  parameter int FRAC_W = fpm_pkg::DEF_FRAC_W,
  localparam int PROD_W = 2 * FRAC_W,
  localparam int CW     = $clog2(FRAC_W + 1)
) (
  input  logic              clk,
  input  logic              clr,
  input  logic [FRAC_W-1:0] mag_a,
  input  logic [FRAC_W-1:0] mag_b,
  output logic [PROD_W-1:0] acc,
  output logic              fin,
  output logic [CW-1:0]     steps
);
  localparam logic [CW-1:0] STEP_MAX = CW'(FRAC_W);

  logic [PROD_W-1:0] mcand;
  logic [FRAC_W-1:0] mplier;
  logic              step_evt;
  logic              add_evt;

  assign fin      = (mplier == '0);
  assign step_evt = !clr && !fin;
  assign add_evt  = step_evt && mplier[0];

  always_ff @(posedge clk) begin
    if (clr) begin
      mcand  <= {{FRAC_W{1'b0}}, mag_a};
      mplier <= (mag_a == '0) ? '0 : mag_b;
      acc    <= '0;
      steps  <= '0;
    end else if (step_evt) begin
      if (add_evt) acc <= acc + mcand;
      mcand  <= mcand << 1;
      mplier <= mplier >> 1;
      steps  <= steps + CW'(1);
    end
  end

  // R1
  start_clear_chk: assert property (@(posedge clk) disable iff (clr)
    $past(clr) |-> (steps == '0) && (acc == '0));

  // R10
  step_bound_chk: assert property (@(posedge clk) disable iff (clr)
    !fin |-> steps < STEP_MAX);

  // R2
  acc_monotone_chk: assert property (@(posedge clk) disable iff (clr)
    !fin |=> acc >= $past(acc));
endmodule

// File: rtl/fpm_mul.sv
module fpm_mul #(
  parameter int EXP_W  = fpm_pkg::DEF_EXP_W,
  parameter int FRAC_W = fpm_pkg::DEF_FRAC_W,
  localparam int WORD_W = EXP_W + FRAC_W,
  localparam int PROD_W = 2 * FRAC_W,
  localparam int OUT_W  = EXP_W + PROD_W,
  localparam int CW     = $clog2(FRAC_W + 1)
) (
  input  logic              clk,
  input  logic              clr,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic [OUT_W-1:0]  product,
  output logic              done,
  output logic              exp_ok
);
  import fpm_pkg::*;

  logic [WORD_W-1:0] ops   [2];
  logic [EXP_W-1:0]  expos [2];
  logic [FRAC_W-1:0] mags  [2];
  logic              negs  [2];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar g = 0; g < 2; g++) begin : g_unpack
    fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
      .word(ops[g]),
      .expo(expos[g]),
      .mag (mags[g]),
      .neg (negs[g])
    );
  end

  logic [EXP_W-1:0]  exp_sum;
  logic [PROD_W-1:0] acc;
  logic [CW-1:0]     steps;
  logic              fin;
  logic              flip_q;
  fpm_phase_e        phase;

  fpm_expadd #(.EXP_W(EXP_W)) u_exp (
    .clk     (clk),
    .clr     (clr),
    .exp_a   (expos[0]),
    .exp_b   (expos[1]),
    .exp_sum (exp_sum),
    .exp_fits(exp_ok)
  );

  fpm_shiftadd #(.FRAC_W(FRAC_W)) u_engine (
    .clk  (clk),
    .clr  (clr),
    .mag_a(mags[0]),
    .mag_b(mags[1]),
    .acc  (acc),
    .fin  (fin),
    .steps(steps)
  );

  always_ff @(posedge clk) begin
    if (clr) flip_q <= negs[0] ^ negs[1];
  end

  function automatic logic [PROD_W-1:0] apply_sign(input logic [PROD_W-1:0] m,
                                                   input logic flip);
    return flip ? (~m + PROD_W'(1)) : m;
  endfunction

  assign done    = fin;
  assign product = {exp_sum, apply_sign(acc, flip_q)};
  assign phase   = clr ? PH_LOAD : (fin ? PH_DONE : PH_RUN);

  // R4
  result_hold_chk: assert property (@(posedge clk) disable iff (clr)
    phase == PH_DONE |=> phase == PH_DONE && $stable(product) && $stable(exp_ok));

  // R5
  sign_match_chk: assert property (@(posedge clk) disable iff (clr)
    (done && acc != '0) |-> product[PROD_W-1] == flip_q);

  // R3
  step_progress_chk: assert property (@(posedge clk) disable iff (clr)
    phase == PH_RUN |=> steps == $past(steps) + CW'(1));
endmodule

// File: tb/tb_fpm_mul.sv
module tb_fpm_mul;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        clr = 1'b1;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [55:0] product;
  logic        done;
  logic        exp_ok;

  fpm_mul dut (
    .clk(clk), .clr(clr), .op_a(op_a), .op_b(op_b),
    .product(product), .done(done), .exp_ok(exp_ok)
  );

  typedef struct {
    logic [7:0]  ex;
    logic [47:0] fr;
    logic        ok;
    int          cyc;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   ended  = 0;
  event launched, finished;

  task automatic check(input bit cond, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [31:0] a, input logic [31:0] b);
    exp_t   e;
    int     fa, fb, es, mb;
    longint p;
    fa = $signed(a[23:0]);
    fb = $signed(b[23:0]);
    p  = longint'(fa) * longint'(fb);
    es = int'($signed(a[31:24])) + int'($signed(b[31:24]));
    e.fr = p[47:0];
    e.ex = es[7:0];
    e.ok = (es >= -128) && (es <= 127);
    mb = (fb < 0) ? -fb : fb;
    e.cyc = 0;
    if (fa != 0) begin
      while (mb != 0) begin
        mb = mb >> 1;
        e.cyc++;
      end
    end
    return e;
  endfunction

  task automatic run_op(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    clr  = 1'b1;
    op_a = a;
    op_b = b;
    q.push_back(model(a, b));
    @(negedge clk);
    clr  = 1'b0;
    // R9: scramble the operands once they have been captured
    op_a = ~a;
    op_b = b ^ 32'h5a5a_5a5a;
    -> launched;
    @(finished);
  endtask

  initial begin : monitor
    forever begin
      exp_t        e;
      int          cnt;
      logic [55:0] held;
      @(launched);
      cnt = 0;
      while (!done && cnt < 40) begin
        @(negedge clk);
        cnt++;
      end
      e = q.pop_front();
      check(cnt == e.cyc, "R3", "cycles to done", 64'(cnt), 64'(e.cyc));
      check(cnt <= 24, "R10", "completion bound", 64'(cnt), 64'd24);
      check(product[47:0] == e.fr, "R2", "fraction", 64'(product[47:0]), 64'(e.fr));
      check(product[55:48] == e.ex, "R6", "exponent", 64'(product[55:48]), 64'(e.ex));
      check(exp_ok == e.ok, "R7", "exp_ok", 64'(exp_ok), 64'(e.ok));
      check(product[47] == (e.fr[47]), "R5", "sign", 64'(product[47]), 64'(e.fr[47]));
      held = product;
      repeat (3) begin
        @(negedge clk);
        check(done && product == held, "R4", "hold after done", 64'(product), 64'(held));
      end
      -> finished;
    end
  end

  initial begin : watchdog
    #(5.0 * 100000);
    if (!ended) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    clr = 1'b0;
    @(negedge clk);
    // R8: start state with zero operands
    check(done == 1'b1, "R8", "done after reset", 64'(done), 64'd1);
    check(product == '0, "R8", "product after reset", 64'(product), 64'd0);
    check(exp_ok == 1'b1, "R7", "exp_ok after reset", 64'(exp_ok), 64'd1);

    run_op({8'sd1, 24'd3},         {8'sd2, 24'd5});
    run_op({8'sd0, -24'sd3},       {8'sd4, 24'd5});        // R5
    run_op({-8'sd3, -24'sd7},      {8'sd1, -24'sd9});      // R5
    run_op({8'sd0, 24'h7fffff},    {8'sd0, 24'h7fffff});
    run_op({8'sd5, 24'h800000},    {-8'sd5, 24'h800000});  // R10: full 24 steps
    run_op({8'sd0, 24'h123456},    {8'sd0, 24'd1});        // R3: one step
    run_op({8'sd7, 24'd0},         {8'sd1, 24'h654321});   // R8: zero A
    run_op({8'sd2, -24'sd77},      {8'sd3, 24'd0});        // R8: zero B
    run_op({8'sd100, 24'd9},       {8'sd100, 24'd11});     // R7: positive overflow
    run_op({-8'sd100, 24'd9},      {-8'sd100, -24'sd11});  // R7: negative overflow
    run_op({8'sd127, 24'd2},       {8'sd0, 24'd2});        // R6: top of range
    run_op({-8'sd128, 24'd2},      {-8'sd1, 24'd2});       // R7: just below range
    // R1: same operands twice, each needs its own start
    run_op({8'sd1, 24'h00abcd},    {8'sd1, -24'sd1234});
    run_op({8'sd1, 24'h00abcd},    {8'sd1, -24'sd1234});
    // R1: abandon a long operation partway, then start a new one
    @(negedge clk);
    clr  = 1'b1;
    op_a = {8'sd9, 24'h7fffff};
    op_b = {8'sd9, 24'h7ffff0};
    @(negedge clk);
    clr = 1'b0;
    repeat (4) @(negedge clk);
    run_op({8'sd2, 24'd6},         {8'sd2, -24'sd7});

    ended = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule